// File: doc/BRIEF.md
# Lane Alignment Marker Parity Inserter

This block sits on the transmit side of one lane of a 64b/66b physical coding sublayer. It takes a stream of 66-bit blocks through a valid/ready input and drives a registered 66-bit output. At a fixed interval, counted in emitted blocks, it sends an alignment marker ahead of the payload stream. Every marker carries an 8-bit bit-interleaved parity value in one byte, with the complement of that value in the mirrored byte.

The parity value covers the previous marker, exactly as it was sent, and every data block sent after it. The accumulator is cleared whenever a marker is emitted. The first marker after reset therefore carries a parity of zero. During the marker cycle the input is not ready, so the upstream stream stalls for one cycle. A 24-bit input supplies the three marker pattern bytes.

Top module: `lane_bip_inserter`

## Requirements
- R1: A marker has blkOut[0]=1 and blkOut[1]=0. Payload octet n sits at bits 8n+2..8n+9, with bit 8n+2 as its LSB. Octets 0, 1 and 2 carry markerPat[7:0], [15:8] and [23:16]. Octets 4, 5 and 6 carry the complements of those three bytes.
- R2: Octet 3 of a marker carries the parity byte, and octet 7 carries its bitwise complement.
- R3: Markers repeat every PERIOD emitted blocks. Exactly PERIOD-1 accepted data blocks separate two markers.
- R4: inReady is low exactly in the cycle in which a marker is emitted. A block offered in that cycle is not consumed, and it goes out after the marker once it is offered again.
- R5: A block accepted with inValid and inReady both high appears unchanged on blkOut, with outValid high, one clock later.
- R6: With inValid low and inReady high, outValid is low in the next cycle and the marker schedule does not advance.
- R7: Parity bit k is the even parity of bit k of every payload octet in all blocks sent since the previous marker, that marker included.
- R8: Parity bit 4 also covers blkOut[0], and parity bit 3 also covers blkOut[1], of every covered block.
- R9: The first marker after reset is emitted in the first cycle out of reset and carries a parity byte of 0x00.
- R10: A marker's own bits, including its parity and complement bytes, count toward the parity carried by the next marker.
- R11: During reset, outValid and inReady are low.
- R12: The marker pattern is taken from markerPat as it stands in the cycle in which the marker is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An input block is offered |
| inReady | output | 1 | The block accepts input; low during a marker cycle |
| blkIn | input | 66 | Input block, sync header in bits 1:0 |
| markerPat | input | 24 | Marker pattern bytes, byte 0 in bits 7:0 |
| outValid | output | 1 | blkOut holds a block |
| blkOut | output | 66 | Output block, marker or data |

## Verification
The bench sends a held block into the marker cycle. A design that consumed it would lose the block or send it twice. It sends spans made only of sync-header variations with zero payload, which expose parity that ignores the header bits or folds them into the wrong parity positions. It inserts long idle gaps in the middle of a span, and a design that counted clock cycles instead of blocks would then place a marker early. It also changes the marker pattern between markers and checks the first marker's zero parity, which catch a stale pattern register and an accumulator that is not cleared.

// File: rtl/lane_bip_pkg.sv
package lane_bip_pkg;
  localparam int BLK_W     = 66;
  localparam int SYNC_W    = 2;
  localparam int OCTET_W   = 8;
  localparam int OCTETS    = (BLK_W - SYNC_W) / OCTET_W;
  localparam int PAT_W     = 3 * OCTET_W;
  localparam int BIP_OCTET = 3;

  typedef logic [BLK_W-1:0]   blk_t;
  typedef logic [OCTET_W-1:0] octet_t;
  typedef logic [PAT_W-1:0]   pat_t;

  localparam logic [SYNC_W-1:0] SYNC_MARKER = 2'b01;

  typedef struct packed {
    logic emitMarker;
    logic takeData;
  } ctl_t;

  function automatic octet_t blockParity(input blk_t b);
    octet_t p;
    p = '0;
    for (int n = 0; n < OCTETS; n++) begin
      p ^= b[SYNC_W + OCTET_W*n +: OCTET_W];
    end
    p[4] ^= b[0];
    p[3] ^= b[1];
    return p;
  endfunction

  function automatic blk_t buildMarker(input pat_t pat, input octet_t bip);
    blk_t w;
    w = '0;
    w[SYNC_W-1:0] = SYNC_MARKER;
    w[SYNC_W +: PAT_W] = pat;
    w[SYNC_W + OCTET_W*BIP_OCTET +: OCTET_W] = bip;
    w[SYNC_W + OCTET_W*(BIP_OCTET+1) +: PAT_W] = ~pat;
    w[SYNC_W + OCTET_W*(2*BIP_OCTET+1) +: OCTET_W] = ~bip;
    return w;
  endfunction
endpackage

// File: rtl/lane_bip_ctrl.sv
module lane_bip_ctrl
  import lane_bip_pkg::*;
#(
  parameter int PERIOD = 16384
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output logic inReady,
  output ctl_t ctl
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] slotCnt;
  logic             advance;

  always_comb begin
    ctl.emitMarker = (slotCnt == '0) && rstN;
    ctl.takeData   = (slotCnt != '0) && inValid && rstN;
    inReady        = (slotCnt != '0) && rstN;
    advance        = ctl.emitMarker || ctl.takeData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (advance) begin
      slotCnt <= (slotCnt == LAST_SLOT) ? '0 : slotCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_bip_datapath.sv
module lane_bip_datapath
  import lane_bip_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  ctl_t ctl,
  input  blk_t blkIn,
  input  pat_t markerPat,
  output blk_t blkOut,
  output logic outValid
);
  octet_t acc;
  blk_t   markerWord;
  blk_t   nextWord;
  octet_t wordParity;

  always_comb begin
    markerWord = buildMarker(markerPat, acc);
    nextWord   = ctl.emitMarker ? markerWord : blkIn;
    wordParity = blockParity(nextWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      blkOut   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.emitMarker || ctl.takeData;
      if (ctl.emitMarker) begin
        blkOut <= markerWord;
        acc    <= wordParity;
      end else if (ctl.takeData) begin
        blkOut <= blkIn;
        acc    <= acc ^ wordParity;
      end
    end
  end
endmodule

// File: rtl/lane_bip_inserter.sv
module lane_bip_inserter
  import lane_bip_pkg::*;
#(
  parameter int PERIOD = 16384
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [65:0] blkIn,
  input  logic [23:0] markerPat,
  output logic        outValid,
  output logic [65:0] blkOut
);
  ctl_t ctl;

  lane_bip_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .ctl     (ctl)
  );

  lane_bip_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .blkIn     (blkIn),
    .markerPat (markerPat),
    .blkOut    (blkOut),
    .outValid  (outValid)
  );
endmodule

// File: rtl/lane_bip_checker.sv
module lane_bip_checker #(
  parameter int PERIOD = 16384
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inReady,
  input logic [65:0] blkIn,
  input logic [23:0] markerPat,
  input logic        outValid,
  input logic [65:0] blkOut
);
  int   dataSince;
  logic seenMarker;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSince  <= 0;
      seenMarker <= 1'b0;
    end else if (!inReady) begin
      dataSince  <= 0;
      seenMarker <= 1'b1;
    end else if (inValid) begin
      dataSince <= dataSince + 1;
    end
  end

  // R1 R12: marker cycle yields sync 01 and the current pattern
  a_r1_marker_layout: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> (outValid && blkOut[1:0] == 2'b01 && blkOut[25:2] == $past(markerPat)));

  // R2: upper half of a marker mirrors the lower half inverted
  a_r2_bip_complement: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> (blkOut[65:34] == ~blkOut[33:2]));

  // R3: marker spacing in accepted blocks
  a_r3_period: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && seenMarker) |-> (dataSince == PERIOD - 1));

  // R5: accepted block passes unchanged
  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid && blkOut == $past(blkIn)));

  // R6: idle input gives no output
  a_r6_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && inReady) |=> !outValid);

  // R4: ready is never low for two cycles in a row
  a_r4_single_stall: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && seenMarker) |=> inReady);
endmodule

bind lane_bip_inserter lane_bip_checker #(.PERIOD(PERIOD)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inReady   (inReady),
  .blkIn     (blkIn),
  .markerPat (markerPat),
  .outValid  (outValid),
  .blkOut    (blkOut)
);

// File: tb/lane_bip_inserter_tb_top.sv
module lane_bip_inserter_tb_top;
  localparam int PERIOD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [65:0] blkIn = '0;
  logic [23:0] markerPat = 24'h5A3C96;
  logic        outValid;
  logic [65:0] blkOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  int          slot = 0;
  logic [7:0]  acc = '0;
  logic        expValid = 1'b0;
  logic        expMarker = 1'b0;
  logic        expFirst = 1'b0;
  logic [65:0] expBlk = '0;
  logic [7:0]  expBip = '0;
  logic [23:0] expPat = '0;
  int          markerCount = 0;

  always #2.5 clk = ~clk;

  lane_bip_inserter #(.PERIOD(PERIOD)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .blkIn(blkIn), .markerPat(markerPat), .outValid(outValid), .blkOut(blkOut)
  );

  function automatic logic [7:0] refParity(input logic [65:0] b);
    logic [7:0] p = '0;
    for (int n = 0; n < 8; n++) p ^= b[2 + 8*n +: 8];
    p[4] ^= b[0];
    p[3] ^= b[1];
    return p;
  endfunction

  function automatic logic [65:0] refMarker(input logic [23:0] pat, input logic [7:0] bip);
    return {~bip, ~pat, bip, pat, 2'b01};
  endfunction

  function automatic logic [65:0] randBlk();
    logic [31:0] a = $urandom;
    logic [31:0] b = $urandom;
    logic [1:0]  s = 2'($urandom);
    return {a, b, s};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [65:0] d);
    logic [65:0] mk;
    chk(inReady == (slot != 0), "R4 ready", 66'(inReady), 66'(slot != 0));
    inValid = v;
    blkIn = d;
    if (slot == 0) begin
      mk = refMarker(markerPat, acc);
      expBip = acc;
      expPat = markerPat;
      expFirst = (markerCount == 0);
      markerCount++;
      expBlk = mk;
      expValid = 1'b1;
      expMarker = 1'b1;
      acc = refParity(mk);
      slot = 1;
    end else if (v) begin
      expBlk = d;
      expValid = 1'b1;
      expMarker = 1'b0;
      acc ^= refParity(d);
      slot = (slot + 1) % PERIOD;
    end else begin
      expValid = 1'b0;
      expMarker = 1'b0;
    end
    @(negedge clk);
    if (!expValid) begin
      chk(outValid == 1'b0, "R6 idle outValid", 66'(outValid), 66'(0));
    end else if (expMarker) begin
      chk(outValid == 1'b1, "R3 marker valid", 66'(outValid), 66'(1));
      chk(blkOut[25:0] == {expPat, 2'b01}, "R1 R12 marker header", 66'(blkOut[25:0]), 66'({expPat, 2'b01}));
      chk(blkOut[57:34] == ~expPat, "R1 complement pattern", 66'(blkOut[57:34]), 66'(~expPat));
      if (expFirst)
        chk(blkOut[33:26] == 8'h00, "R9 first bip", 66'(blkOut[33:26]), 66'(0));
      else
        chk(blkOut[33:26] == expBip, "R7 R8 R10 bip", 66'(blkOut[33:26]), 66'(expBip));
      chk(blkOut[65:58] == ~expBip, "R2 inverted bip", 66'(blkOut[65:58]), 66'(~expBip));
    end else begin
      chk(outValid && blkOut == expBlk, "R5 data", blkOut, expBlk);
    end
  endtask

  // offers held blocks until accepted (R4: marker cycle does not consume)
  task automatic runRandom(input int n, input int pct);
    logic        have = 1'b0;
    logic [65:0] pend = '0;
    logic        taken;
    for (int i = 0; i < n; i++) begin
      if (!have && ($urandom % 100) < pct) begin
        pend = randBlk();
        have = 1'b1;
      end
      taken = have && (slot != 0);
      step(have, pend);
      if (taken) have = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R11 reset outValid", 66'(outValid), 66'(0));
    chk(inReady == 1'b0, "R11 reset inReady", 66'(inReady), 66'(0));
    rstN = 1'b1;
    // R9 first marker, R4 block offered in marker cycle is held
    begin
      logic [65:0] held = randBlk();
      step(1'b1, held);
      step(1'b1, held);
    end
    // R8: sync-only payload spans
    for (int i = 0; i < 2 * PERIOD; i++) begin
      logic [1:0] s = 2'(i % 3);
      step(1'b1, {64'h0, s});
    end
    // R6: long idle gap mid-span must not move the marker
    for (int i = 0; i < 3; i++) step(1'b1, randBlk());
    for (int i = 0; i < 20; i++) step(1'b0, randBlk());
    // R12: pattern change between markers
    markerPat = 24'hC3A51E;
    runRandom(3 * PERIOD, 100);
    markerPat = 24'h0F0F0F;
    // R7 R10 R3: random traffic
    runRandom(400, 70);
    runRandom(200, 20);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule